// File: doc/BRIEF.md
# Vertical Sync Line Filter and Pulse Regenerator

This block conditions the frame-rate synchronisation pulse of a video receiver. It accepts two candidate vertical sync inputs: a dedicated pin, and the output of a composite sync separator that lives elsewhere. The block picks one of them and converts its polarity to an internal active-high form. It then either passes the result straight through or cleans it against the line rate. A one-cycle horizontal sync strobe, produced by the line timing logic, marks each line.

With the line filter on, the vertical level is sampled once per line strobe. The output follows a new level only after two consecutive line samples agree, so a pulse one line wide is removed and every edge lands on a line boundary. With the regenerator also on, each filtered pulse is replaced by a pulse that lasts a programmed number of lines. Further activity is ignored until the input has been seen inactive again. The final output polarity is programmable. Source choice and input polarity can each be forced by override inputs or left to automatic detection. Control bits arrive as static inputs from a register block outside this design. That block is expected to reset the duration count to 10 lines, the output polarity to active high, and both the filter and the regenerator to off.

Top module: `vsync_regen`

## Requirements
- R1: With `src_ovr_i`=1, `src_sel_i`=0 selects `vs_pin_i` and `src_sel_i`=1 selects `vs_sep_i`; the unselected input has no effect on `vs_o`.
- R2: With `src_ovr_i`=0, the pin is used whenever `vs_pin_i` has changed level within the last `IDLE_LINES` line strobes, otherwise the separator is used; after reset the separator is used until the pin changes.
- R3: With `pol_ovr_i`=1, `pol_in_i`=1 treats a high selected input as active, and `pol_in_i`=0 treats a low selected input as active.
- R4: With `pol_ovr_i`=0, the active level is the one whose most recent run, measured in line strobes, was shorter; after reset active high is assumed.
- R5: `out_pol_i`=1 drives `vs_o` high while active; `out_pol_i`=0 drives it low while active.
- R6: With `filt_en_i`=0, `vs_o` follows the normalised selected input in the same cycle and `dur_en_i` has no effect.
- R7: With `filt_en_i`=1 and `dur_en_i`=0, the input is sampled on each strobe, and the output takes a new level in the cycle after the strobe at which two consecutive samples agree. An input active for lines a..a+A-1 (A>=2) gives an output active for lines a+1..a+A.
- R8: With `filt_en_i`=1, an input active at only one line strobe never makes `vs_o` active.
- R9: With `filt_en_i`=1 and `dur_en_i`=1, the output becomes active in the cycle after the filtered level becomes active. It stays active until the N-th following strobe, where N = `dur_lines_i`, so it is active for lines a+1..a+N.
- R10: After a regenerated pulse ends, continued input activity is ignored; a new pulse starts only after the filtered level has been inactive.
- R11: With `dur_lines_i`=0 in regenerate mode, `vs_o` never becomes active.
- R12: During and after reset, with all inputs inactive, `vs_o` sits at the inactive level given by `out_pol_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_stb_i | input | 1 | One-cycle strobe, once per horizontal line |
| vs_pin_i | input | 1 | Vertical sync from the dedicated pin |
| vs_sep_i | input | 1 | Vertical sync from the sync separator |
| src_ovr_i | input | 1 | 1: source forced by `src_sel_i` |
| src_sel_i | input | 1 | Forced source: 0 pin, 1 separator |
| pol_ovr_i | input | 1 | 1: input polarity forced by `pol_in_i` |
| pol_in_i | input | 1 | Forced input polarity: 1 active high, 0 active low |
| out_pol_i | input | 1 | Output polarity: 1 active high, 0 active low |
| filt_en_i | input | 1 | Enable line-aligned filter |
| dur_en_i | input | 1 | Enable pulse regeneration (only effective with filter on) |
| dur_lines_i | input | LINE_W | Regenerated pulse length in line strobes |
| vs_o | output | 1 | Conditioned vertical sync |

## Verification
The bench builds the block with `IDLE_LINES`=6, `LINE_W`=4 and `RUN_W`=5. The short idle window makes both ways of switching the automatic source reachable within a few lines. The narrow run counters let the polarity detector settle after a couple of frames. A full sweep then covers every combination of output polarity, forced input polarity, forced source and filter/regenerate mode. Each combination is tried with pulse widths of 1, 2, 3 and 5 lines, plus durations 0, 1, 2 and 4 in regenerate mode, and the expected output for each line is computed from the pulse start, its width and the duration.

// File: rtl/vsync_regen_pkg.sv
package vsync_regen_pkg;

    typedef enum logic [1:0] {
        DUR_IDLE = 2'd0,
        DUR_RUN  = 2'd1,
        DUR_HOLD = 2'd2
    } dur_state_e;

    function automatic logic to_active_high(input logic raw, input logic act_high);
        return act_high ? raw : ~raw;
    endfunction

endpackage

// File: rtl/vsf_src_sel.sv
module vsf_src_sel #(
    parameter int IDLE_LINES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_stb_i,
    input  logic pin_i,
    input  logic sep_i,
    input  logic ovr_i,
    input  logic sel_i,
    output logic raw_o
);
    localparam int CW = $clog2(IDLE_LINES + 1);
    localparam logic [CW-1:0] IDLE_MAX = CW'(IDLE_LINES);

    typedef struct packed {
        logic          pin_prev;
        logic [CW-1:0] idle;
    } st_t;

    st_t s_d, s_q;
    logic use_sep;

    always_comb begin
        s_d = s_q;
        s_d.pin_prev = pin_i;
        if (pin_i != s_q.pin_prev) begin
            s_d.idle = '0;
        end else if (hs_stb_i && (s_q.idle != IDLE_MAX)) begin
            s_d.idle = s_q.idle + CW'(1);
        end
        use_sep = ovr_i ? sel_i : (s_q.idle == IDLE_MAX);
        raw_o   = use_sep ? sep_i : pin_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pin_prev <= 1'b0;
            s_q.idle     <= IDLE_MAX;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/vsf_pol_norm.sv
module vsf_pol_norm
    import vsync_regen_pkg::*;
#(
    parameter int RUN_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_stb_i,
    input  logic raw_i,
    input  logic ovr_i,
    input  logic pol_i,
    output logic norm_o
);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    typedef struct packed {
        logic             lvl;
        logic [RUN_W-1:0] run;
        logic [RUN_W-1:0] hi_len;
        logic [RUN_W-1:0] lo_len;
        logic             act_high;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (raw_i != s_q.lvl) begin
            s_d.lvl = raw_i;
            s_d.run = '0;
            if (s_q.lvl) begin
                s_d.hi_len   = s_q.run;
                s_d.act_high = (s_q.run < s_q.lo_len);
            end else begin
                s_d.lo_len   = s_q.run;
                s_d.act_high = (s_q.hi_len < s_q.run);
            end
        end else if (hs_stb_i && (s_q.run != RUN_MAX)) begin
            s_d.run = s_q.run + RUN_W'(1);
        end
        norm_o = to_active_high(raw_i, ovr_i ? pol_i : s_q.act_high);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.lvl      <= 1'b0;
            s_q.run      <= '0;
            s_q.hi_len   <= '0;
            s_q.lo_len   <= '0;
            s_q.act_high <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/vsf_line_filter.sv
module vsf_line_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_stb_i,
    input  logic en_i,
    input  logic norm_i,
    output logic filt_o
);
    typedef struct packed {
        logic smp;
        logic held;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (hs_stb_i) begin
            s_d.smp = norm_i;
            if (norm_i == s_q.smp) begin
                s_d.held = norm_i;
            end
        end
        filt_o = en_i ? s_q.held : norm_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.smp  <= 1'b0;
            s_q.held <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/vsf_dur_gen.sv
module vsf_dur_gen
    import vsync_regen_pkg::*;
#(
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_stb_i,
    input  logic              en_i,
    input  logic              filt_i,
    input  logic [LINE_W-1:0] len_i,
    output logic              act_o
);
    localparam logic [LINE_W-1:0] ONE = LINE_W'(1);

    typedef struct packed {
        dur_state_e        st;
        logic [LINE_W-1:0] left;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!en_i) begin
            s_d.st   = DUR_IDLE;
            s_d.left = '0;
        end else begin
            unique case (s_q.st)
                DUR_IDLE: begin
                    if (filt_i) begin
                        if (len_i == '0) begin
                            s_d.st = DUR_HOLD;
                        end else begin
                            s_d.st   = DUR_RUN;
                            s_d.left = len_i;
                        end
                    end
                end
                DUR_RUN: begin
                    if (hs_stb_i) begin
                        if (s_q.left <= ONE) begin
                            s_d.st   = filt_i ? DUR_HOLD : DUR_IDLE;
                            s_d.left = '0;
                        end else begin
                            s_d.left = s_q.left - ONE;
                        end
                    end
                end
                DUR_HOLD: begin
                    if (!filt_i) begin
                        s_d.st = DUR_IDLE;
                    end
                end
                default: begin
                    s_d.st = DUR_IDLE;
                end
            endcase
        end
        act_o = en_i ? (s_q.st == DUR_RUN) : filt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= DUR_IDLE;
            s_q.left <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/vsync_regen.sv
module vsync_regen #(
    parameter int IDLE_LINES = 16,
    parameter int RUN_W      = 10,
    parameter int LINE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_stb_i,
    input  logic              vs_pin_i,
    input  logic              vs_sep_i,
    input  logic              src_ovr_i,
    input  logic              src_sel_i,
    input  logic              pol_ovr_i,
    input  logic              pol_in_i,
    input  logic              out_pol_i,
    input  logic              filt_en_i,
    input  logic              dur_en_i,
    input  logic [LINE_W-1:0] dur_lines_i,
    output logic              vs_o
);
    logic raw_sel;
    logic norm;
    logic filt;
    logic act;
    logic regen_en;

    assign regen_en = filt_en_i & dur_en_i;

    vsf_src_sel #(.IDLE_LINES(IDLE_LINES)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_stb_i (hs_stb_i),
        .pin_i    (vs_pin_i),
        .sep_i    (vs_sep_i),
        .ovr_i    (src_ovr_i),
        .sel_i    (src_sel_i),
        .raw_o    (raw_sel)
    );

    vsf_pol_norm #(.RUN_W(RUN_W)) u_pol (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_stb_i (hs_stb_i),
        .raw_i    (raw_sel),
        .ovr_i    (pol_ovr_i),
        .pol_i    (pol_in_i),
        .norm_o   (norm)
    );

    vsf_line_filter u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_stb_i (hs_stb_i),
        .en_i     (filt_en_i),
        .norm_i   (norm),
        .filt_o   (filt)
    );

    vsf_dur_gen #(.LINE_W(LINE_W)) u_dur (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_stb_i (hs_stb_i),
        .en_i     (regen_en),
        .filt_i   (filt),
        .len_i    (dur_lines_i),
        .act_o    (act)
    );

    assign vs_o = out_pol_i ? act : ~act;
endmodule

// File: rtl/vsync_regen_chk.sv
module vsync_regen_chk #(
    parameter int LINE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hs_stb_i,
    input logic              vs_pin_i,
    input logic              vs_sep_i,
    input logic              src_ovr_i,
    input logic              src_sel_i,
    input logic              pol_ovr_i,
    input logic              pol_in_i,
    input logic              out_pol_i,
    input logic              filt_en_i,
    input logic              dur_en_i,
    input logic [LINE_W-1:0] dur_lines_i,
    input logic              vs_o
);
    logic out_act;
    logic regen_mode;
    logic filt_only;
    logic [LINE_W-1:0] seen_q;

    assign out_act    = (vs_o == out_pol_i);
    assign regen_mode = filt_en_i & dur_en_i;
    assign filt_only  = filt_en_i & ~dur_en_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (!(regen_mode && out_act)) begin
            seen_q <= '0;
        end else if (hs_stb_i && (seen_q != '1)) begin
            seen_q <= seen_q + LINE_W'(1);
        end
    end

    // R6
    bypass_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!filt_en_i && src_ovr_i && pol_ovr_i) |->
            (vs_o == (((src_sel_i ? vs_sep_i : vs_pin_i) == pol_in_i) == out_pol_i)));

    // R7
    filter_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_only && $past(filt_only) && $stable(out_pol_i) && !$past(hs_stb_i)) |->
            $stable(vs_o));

    // R9
    regen_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regen_mode && out_act) |-> (seen_q < dur_lines_i));

    // R9
    regen_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regen_mode && $past(regen_mode) && $past(regen_mode, 2) &&
         $stable(out_pol_i) && $rose(out_act)) |-> $past(hs_stb_i, 2));
endmodule

bind vsync_regen vsync_regen_chk #(.LINE_W(LINE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hs_stb_i    (hs_stb_i),
    .vs_pin_i    (vs_pin_i),
    .vs_sep_i    (vs_sep_i),
    .src_ovr_i   (src_ovr_i),
    .src_sel_i   (src_sel_i),
    .pol_ovr_i   (pol_ovr_i),
    .pol_in_i    (pol_in_i),
    .out_pol_i   (out_pol_i),
    .filt_en_i   (filt_en_i),
    .dur_en_i    (dur_en_i),
    .dur_lines_i (dur_lines_i),
    .vs_o        (vs_o)
);

// File: tb/vsync_regen_tb.sv
module vsync_regen_tb;
    localparam int IDLE_LINES = 6;
    localparam int RUN_W      = 5;
    localparam int LINE_W     = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_stb = 1'b0;
    logic vs_pin = 1'b0;
    logic vs_sep = 1'b0;
    logic src_ovr = 1'b1;
    logic src_sel = 1'b0;
    logic pol_ovr = 1'b1;
    logic pol_in = 1'b1;
    logic out_pol = 1'b1;
    logic filt_en = 1'b0;
    logic dur_en = 1'b0;
    logic [LINE_W-1:0] dur_lines = '0;
    logic vs_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic act_lvl = 1'b1;

    always #2 clk = ~clk;

    vsync_regen #(.IDLE_LINES(IDLE_LINES), .RUN_W(RUN_W), .LINE_W(LINE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .hs_stb_i(hs_stb),
        .vs_pin_i(vs_pin), .vs_sep_i(vs_sep),
        .src_ovr_i(src_ovr), .src_sel_i(src_sel),
        .pol_ovr_i(pol_ovr), .pol_in_i(pol_in), .out_pol_i(out_pol),
        .filt_en_i(filt_en), .dur_en_i(dur_en), .dur_lines_i(dur_lines),
        .vs_o(vs_o)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: vs_o got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // expected active state of a line, rel lines after the input went active
    function automatic bit exp_act(input int rel, input int len);
        int n;
        n = int'(dur_lines);
        if (!filt_en) return (rel >= 0) && (rel < len);
        if (!dur_en) return (len >= 2) && (rel >= 1) && (rel <= len);
        return (len >= 2) && (n >= 1) && (rel >= 1) && (rel <= n);
    endfunction

    // one line: strobe, then sample two cycles after the strobe edge
    task automatic drive_line(input logic pin, input logic sep, input int chk, input bit ex,
                              input string tag);
        @(negedge clk);
        hs_stb = 1'b1;
        vs_pin = pin;
        vs_sep = sep;
        @(negedge clk);
        hs_stb = 1'b0;
        @(negedge clk);
        if (chk != 0) check(vs_o, ex ? out_pol : ~out_pol, tag);
        @(negedge clk);
    endtask

    // chk: 0 none, 1 expect inactive, 2 follow requirement model
    task automatic run_frame(input int pre, input int len, input int post, input bit on_sep,
                             input bit other_inv, input int chk, input string tag);
        for (int l = 0; l < pre + len + post; l++) begin
            bit a;
            logic lv, ov;
            bit ex;
            a  = (l >= pre) && (l < pre + len);
            lv = a ? act_lvl : ~act_lvl;
            ov = (other_inv && a) ? act_lvl : ~act_lvl;
            ov = other_inv ? ~lv : ~act_lvl;
            ex = (chk == 2) ? exp_act(l - pre, len) : 1'b0;
            if (on_sep) drive_line(ov, lv, chk, ex, tag);
            else        drive_line(lv, ov, chk, ex, tag);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R12: reset state, then R5 inactive level flips with output polarity
        repeat (3) @(negedge clk);
        check(vs_o, 1'b0, "R12 during reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(vs_o, 1'b0, "R12 after reset");
        out_pol = 1'b0;
        @(negedge clk);
        check(vs_o, 1'b1, "R5 inactive level low-active");
        out_pol = 1'b1;

        // R4: automatic polarity, reset assumes active high
        pol_ovr = 1'b0;
        src_ovr = 1'b1;
        src_sel = 1'b0;
        act_lvl = 1'b1;
        run_frame(2, 2, 2, 1'b0, 1'b0, 2, "R4 reset assumption");
        act_lvl = 1'b0;
        run_frame(8, 2, 0, 1'b0, 1'b0, 0, "R4 warmup low");
        run_frame(8, 2, 0, 1'b0, 1'b0, 0, "R4 warmup low");
        run_frame(8, 2, 0, 1'b0, 1'b0, 0, "R4 warmup low");
        run_frame(8, 2, 0, 1'b0, 1'b0, 2, "R4 active low detected");
        run_frame(8, 2, 2, 1'b0, 1'b0, 2, "R4 active low detected");
        act_lvl = 1'b1;
        run_frame(8, 2, 0, 1'b0, 1'b0, 0, "R4 warmup high");
        run_frame(8, 2, 0, 1'b0, 1'b0, 0, "R4 warmup high");
        run_frame(8, 2, 0, 1'b0, 1'b0, 0, "R4 warmup high");
        run_frame(8, 2, 2, 1'b0, 1'b0, 2, "R4 active high detected");

        // R2: automatic source choice
        pol_ovr = 1'b1;
        pol_in  = 1'b1;
        act_lvl = 1'b1;
        src_ovr = 1'b0;
        run_frame(8, 2, 2, 1'b1, 1'b0, 2, "R2 idle pin uses separator");
        run_frame(0, 2, 1, 1'b0, 1'b0, 2, "R2 pin edge selects pin");
        run_frame(1, 2, 2, 1'b1, 1'b0, 1, "R2 recent pin ignores separator");
        run_frame(8, 2, 2, 1'b1, 1'b0, 2, "R2 pin idle again uses separator");

        // R1 R3 R5 R6 R7 R8 R9 R10 R11: forced source and polarity sweep
        src_ovr = 1'b1;
        for (int op = 0; op < 2; op++) begin
            for (int pi = 0; pi < 2; pi++) begin
                for (int ss = 0; ss < 2; ss++) begin
                    for (int md = 0; md < 4; md++) begin
                        for (int li = 0; li < 4; li++) begin
                            for (int ni = 0; ni < ((md == 2) ? 4 : 1); ni++) begin
                                int len;
                                int nn;
                                string tag;
                                len = (li == 3) ? 5 : li + 1;
                                nn  = (ni == 3) ? 4 : ni;
                                out_pol   = op[0];
                                pol_in    = pi[0];
                                act_lvl   = pi[0];
                                src_sel   = ss[0];
                                filt_en   = (md == 1) || (md == 2);
                                dur_en    = (md >= 2);
                                dur_lines = LINE_W'(nn);
                                if (md == 0 || md == 3) tag = "R6 bypass";
                                else if (md == 1) tag = (len == 1) ? "R8 glitch" : "R7 filter";
                                else if (nn == 0) tag = "R11 zero length";
                                else if (len == 1) tag = "R8 glitch regen";
                                else if (len > nn) tag = "R10 hold regen";
                                else tag = "R9 regen";
                                tag = $sformatf("%s (R1 R3 R5 op=%0d pi=%0d sel=%0d A=%0d N=%0d)",
                                                tag, op, pi, ss, len, nn);
                                run_frame(3, len, 10, ss[0], 1'b1, 2, tag);
                            end
                        end
                    end
                end
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule